// File: doc/BRIEF.md
# Rendering engine control and error register block

This block is the memory-mapped control face of a small vector rendering engine. A host reaches it over a plain 32-bit register bus: one byte address, a write strobe, write data, and combinational read data. It holds the engine's run/stop state, the page-bound checking enable and its two limits, a plane mask, a raster-operation byte, an initial value for general register zero, a diagnostics switch, sticky error capture with an interrupt output, a read-only identity word and a soft-reset trigger. The execution datapath and the instruction queue lie outside the block. It talks to them through simple ports: a general-register write strobe, a queue push port with a full flag and an empty flag, error pulses and a flag that the engine has written memory.

There are two ways to write the 128 general registers. The direct window passes the write straight to the register file in the same cycle, but only while the engine is stopped. The queued window turns the write into a register-load entry pushed onto the instruction queue, whether or not the engine runs. The whole map appears a second time at byte offset 0x1000. That user view reads the same as the privileged view, but writes to the privileged fields are ignored there.

The run state is a two-state machine. `ST_STOPPED` is entered on hard reset, on a soft reset (transition SRESET) and on a status write with the run bit at 0 (transition HALT). `ST_RUNNING` is entered from `ST_STOPPED` by a status write with the run bit at 1 (transition START). A status write with the run bit at 1 while running keeps it running (transition HOLD).

Top module: `rend_ctl_regs`

## Requirements
- R1: After hard reset the status word (offset 0x00) reads 0x8000 while `q_empty_i` is 1. The error, page-bound, plane-mask, ROP, overflow-counter, diagnostics and R0-init words read 0. Offset 0x28 reads {16'h0, CHIP_REV, ARCH_ID}, with the revision in bits 15:8 and the architecture code in bits 7:0. `go_o` and `irq_o` are 0.
- R2: A write to offset 0x00 sets the run state to bit 14 of the data. `go_o` and status bit 14 show the new state from the next cycle.
- R3: Any write to offset 0x30 returns every register to its reset value and stops the engine, visible from the next cycle.
- R4: Offsets 0x1000 and up read like the same offset minus 0x1000. Through that user view, writes to the page bounds (0x08 lower, 0x0C upper), to status bit 12 and to diagnostics (0x1C) are ignored, while the plane mask stays writable.
- R5: A write to 0x100+4·r while stopped raises `greg_we_o` in that same cycle, with `greg_idx_o`=r and `greg_data_o`=write data. While running, no strobe is raised and error bit 3 is set.
- R6: A write to 0x300+4·r raises `q_push_o` in the same cycle with `q_kind_o`=1, `q_reg_o`=r and `q_data_o`=write data, whatever the run state.
- R7: A write to offset 0x20 pushes the word with `q_kind_o`=0. A word whose bits 31:28 equal 4'h8 is memory-referencing. It is pushed only when diagnostics bit 0 is 1; otherwise it is dropped and error bit 0 is set.
- R8: A push attempt while `q_full_i` is 1 is dropped, sets error bit 5 and increments the counter at 0x18, which saturates at all ones. Any write to 0x18 clears it.
- R9: Error bits 5:0 are set by `eng_err_i` pulses (bit i sets bit i) and by the internal causes. They stay set until 1 is written to that bit at offset 0x00 or 0x04. If a set and a clear of one bit coincide, the set wins. Offset 0x04 reads the errors in bits 5:0 and the interrupt enable in bit 7.
- R10: Bit 7 (interrupt enable) is written at offset 0x00 or 0x04. `irq_o` is 1 exactly when that enable is 1 and any error bit is set.
- R11: Status bit 13 is set by an `eng_wrote_i` pulse and cleared by writing 1 to it at offset 0x00. Status bit 15 follows `q_empty_i`, and bit 12 reads the page-bound enable.
- R12: The plane mask (0x10, 32 bits), the ROP byte (0x14, bits 7:0), R0-init (0x2C) and both page bounds read back what was written and drive their output ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 13 | Byte address; bit 12 selects the user view |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| go_o | output | 1 | Engine run state |
| pb_en_o | output | 1 | Page-bound checking enable |
| pb_lo_o | output | 32 | Lower page bound |
| pb_hi_o | output | 32 | Upper page bound |
| plane_mask_o | output | 32 | Plane mask |
| rop_o | output | 8 | Raster-operation byte |
| r0_init_o | output | 32 | Initial value for general register zero |
| irq_o | output | 1 | Error interrupt |
| greg_we_o | output | 1 | Direct general-register write strobe |
| greg_idx_o | output | 7 | Direct write register index |
| greg_data_o | output | 32 | Direct write data |
| q_push_o | output | 1 | Queue push strobe |
| q_kind_o | output | 1 | Entry kind: 1 register load, 0 instruction |
| q_reg_o | output | 7 | Register index of a load entry |
| q_data_o | output | 32 | Entry data |
| q_full_i | input | 1 | Queue cannot accept an entry |
| q_empty_i | input | 1 | Queue holds no entries |
| eng_err_i | input | 6 | Error pulses from the engine, one per cause |
| eng_wrote_i | input | 1 | Pulse: the engine wrote memory |

## Verification
The assertions assume that the bus carries at most one operation per cycle. This means a soft reset, an overflow-counter write and a push attempt never share a cycle. They also assume that `q_full_i` and the engine pulses change only between clock edges. The bench drives every input on the falling edge, issues one bus write per two cycles, and sends each error pulse on its own. The one exception is a deliberate pulse that coincides with a write-one-to-clear of the same bit. The overflow counter is built four bits wide so that its saturation point is reached within a short sweep.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
    localparam int unsigned BUS_W = 32;
    localparam int unsigned ERR_N = 6;
    localparam int unsigned IDX_W = 7;

    // error cause positions (shared by status and error words)
    localparam int unsigned E_ILL_INSN = 0;
    localparam int unsigned E_REG_ACC  = 3;
    localparam int unsigned E_Q_WRITE  = 5;

    // control bit positions in the status word
    localparam int unsigned SB_IE = 7;
    localparam int unsigned SB_PB = 12;
    localparam int unsigned SB_WO = 13;
    localparam int unsigned SB_GO = 14;

    typedef enum logic [3:0] {
        RS_NONE, RS_STAT, RS_ERR, RS_PBLO, RS_PBHI, RS_PMASK, RS_ROP,
        RS_OVF, RS_DIAG, RS_INSN, RS_ID, RS_R0I, RS_SRST
    } rsel_e;

    typedef enum logic [0:0] {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    typedef struct packed {
        rsel_e            sel;
        logic             user;
        logic             dir_hit;
        logic             que_hit;
        logic [IDX_W-1:0] idx;
    } dec_t;
endpackage

// File: rtl/rcr_decode.sv
module rcr_decode
    import rcr_pkg::*;
#(
    parameter int unsigned NREGS    = 128,
    parameter int unsigned DIR_BASE = 256,
    parameter int unsigned QUE_BASE = 768
) (
    input  logic [12:0] addr_i,
    output dec_t        dec_o
);
    localparam int unsigned OFF_W = 12;
    localparam int unsigned SPAN  = NREGS * 4;

    logic [OFF_W-1:0] off;

    always_comb begin
        off           = addr_i[OFF_W-1:0];
        dec_o         = '0;
        dec_o.user    = addr_i[OFF_W];
        if (off[1:0] == 2'b00) begin
            unique case (off)
                12'h000: dec_o.sel = RS_STAT;
                12'h004: dec_o.sel = RS_ERR;
                12'h008: dec_o.sel = RS_PBLO;
                12'h00C: dec_o.sel = RS_PBHI;
                12'h010: dec_o.sel = RS_PMASK;
                12'h014: dec_o.sel = RS_ROP;
                12'h018: dec_o.sel = RS_OVF;
                12'h01C: dec_o.sel = RS_DIAG;
                12'h020: dec_o.sel = RS_INSN;
                12'h028: dec_o.sel = RS_ID;
                12'h02C: dec_o.sel = RS_R0I;
                12'h030: dec_o.sel = RS_SRST;
                default: dec_o.sel = RS_NONE;
            endcase
            if (off >= OFF_W'(DIR_BASE) && off < OFF_W'(DIR_BASE + SPAN)) begin
                dec_o.dir_hit = 1'b1;
                dec_o.idx     = IDX_W'((off - OFF_W'(DIR_BASE)) >> 2);
            end
            if (off >= OFF_W'(QUE_BASE) && off < OFF_W'(QUE_BASE + SPAN)) begin
                dec_o.que_hit = 1'b1;
                dec_o.idx     = IDX_W'((off - OFF_W'(QUE_BASE)) >> 2);
            end
        end
    end
endmodule

// File: rtl/rcr_runctl.sv
module rcr_runctl
    import rcr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic srst_i,
    input  logic stat_we_i,
    input  logic go_wr_i,
    output logic go_o
);
    run_state_e st_q, st_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_STOPPED;
        else         st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOPPED: begin
                if (!srst_i && stat_we_i && go_wr_i) st_d = ST_RUNNING;   // START
            end
            ST_RUNNING: begin
                if (srst_i) st_d = ST_STOPPED;                            // SRESET
                else if (stat_we_i && !go_wr_i) st_d = ST_STOPPED;        // HALT
            end
            default: st_d = ST_STOPPED;
        endcase
    end

    always_comb go_o = (st_q == ST_RUNNING);

    a_r3_srst_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst_i |=> !go_o);
    a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_we_i && go_wr_i && !srst_i) |=> go_o);
    a_r2_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_we_i && !go_wr_i) |=> !go_o);
endmodule

// File: rtl/rcr_errlog.sv
module rcr_errlog #(
    parameter int unsigned ERR_N = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             srst_i,
    input  logic [ERR_N-1:0] set_i,
    input  logic [ERR_N-1:0] clr_i,
    input  logic             ie_we_i,
    input  logic             ie_wr_i,
    output logic [ERR_N-1:0] err_o,
    output logic             ie_o,
    output logic             irq_o
);
    logic [ERR_N-1:0] err_q;
    logic             ie_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            err_q <= '0;
            ie_q  <= 1'b0;
        end else if (srst_i) begin
            err_q <= '0;
            ie_q  <= 1'b0;
        end else begin
            err_q <= (err_q & ~clr_i) | set_i;
            if (ie_we_i) ie_q <= ie_wr_i;
        end
    end

    assign err_o = err_q;
    assign ie_o  = ie_q;
    assign irq_o = ie_q && (err_q != '0);

    a_r9_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_i) |=> ((err_q & $past(err_q & ~clr_i)) == $past(err_q & ~clr_i)));
    a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!srst_i) |=> ((err_q & $past(set_i)) == $past(set_i)));
    a_r10_irq_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((set_i != '0) && ie_q && !ie_we_i && !srst_i) |=> irq_o);
endmodule

// File: rtl/rend_ctl_regs.sv
module rend_ctl_regs
    import rcr_pkg::*;
#(
    parameter int unsigned NREGS    = 128,
    parameter int unsigned OVF_W    = 16,
    parameter logic [7:0]  ARCH_ID  = 8'h5A,
    parameter logic [7:0]  CHIP_REV = 8'h03
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [12:0]      addr_i,
    input  logic             we_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic             go_o,
    output logic             pb_en_o,
    output logic [31:0]      pb_lo_o,
    output logic [31:0]      pb_hi_o,
    output logic [31:0]      plane_mask_o,
    output logic [7:0]       rop_o,
    output logic [31:0]      r0_init_o,
    output logic             irq_o,
    output logic             greg_we_o,
    output logic [6:0]       greg_idx_o,
    output logic [31:0]      greg_data_o,
    output logic             q_push_o,
    output logic             q_kind_o,
    output logic [6:0]       q_reg_o,
    output logic [31:0]      q_data_o,
    input  logic             q_full_i,
    input  logic             q_empty_i,
    input  logic [5:0]       eng_err_i,
    input  logic             eng_wrote_i
);
    localparam logic [OVF_W-1:0] OVF_MAX = {OVF_W{1'b1}};
    localparam logic [3:0]       MEM_OPC = 4'h8;

    dec_t             dec;
    logic             priv, srst, stat_we, err_we;
    logic             dir_bad, insn_wr, insn_blocked, push_req, overflow;
    logic [ERR_N-1:0] err_set, err_clr, err;
    logic             ie;
    logic             pb_en_q, wo_q, diag_q;
    logic [31:0]      pb_lo_q, pb_hi_q, pmask_q, r0i_q;
    logic [7:0]       rop_q;
    logic [OVF_W-1:0] ovf_q;

    rcr_decode #(.NREGS(NREGS), .DIR_BASE(256), .QUE_BASE(768)) u_dec (
        .addr_i (addr_i),
        .dec_o  (dec)
    );

    always_comb begin
        priv         = !dec.user;
        srst         = we_i && (dec.sel == RS_SRST);
        stat_we      = we_i && (dec.sel == RS_STAT);
        err_we       = we_i && (dec.sel == RS_ERR);
        dir_bad      = we_i && dec.dir_hit && go_o;
        insn_wr      = we_i && (dec.sel == RS_INSN);
        insn_blocked = insn_wr && (wdata_i[31:28] == MEM_OPC) && !diag_q;
        push_req     = (we_i && dec.que_hit) || (insn_wr && !insn_blocked);
        overflow     = push_req && q_full_i;
        err_set                 = eng_err_i;
        err_set[E_REG_ACC]      = err_set[E_REG_ACC] | dir_bad;
        err_set[E_ILL_INSN]     = err_set[E_ILL_INSN] | insn_blocked;
        err_set[E_Q_WRITE]      = err_set[E_Q_WRITE] | overflow;
        err_clr = (stat_we || err_we) ? wdata_i[ERR_N-1:0] : '0;
    end

    rcr_runctl u_run (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .srst_i    (srst),
        .stat_we_i (stat_we),
        .go_wr_i   (wdata_i[SB_GO]),
        .go_o      (go_o)
    );

    rcr_errlog #(.ERR_N(ERR_N)) u_err (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .srst_i  (srst),
        .set_i   (err_set),
        .clr_i   (err_clr),
        .ie_we_i (stat_we || err_we),
        .ie_wr_i (wdata_i[SB_IE]),
        .err_o   (err),
        .ie_o    (ie),
        .irq_o   (irq_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pb_en_q <= 1'b0; wo_q <= 1'b0; diag_q <= 1'b0;
            pb_lo_q <= '0; pb_hi_q <= '0; pmask_q <= '0; r0i_q <= '0;
            rop_q   <= '0; ovf_q   <= '0;
        end else if (srst) begin
            pb_en_q <= 1'b0; wo_q <= 1'b0; diag_q <= 1'b0;
            pb_lo_q <= '0; pb_hi_q <= '0; pmask_q <= '0; r0i_q <= '0;
            rop_q   <= '0; ovf_q   <= '0;
        end else begin
            if (stat_we && priv) pb_en_q <= wdata_i[SB_PB];
            if (eng_wrote_i) wo_q <= 1'b1;
            else if (stat_we && wdata_i[SB_WO]) wo_q <= 1'b0;
            if (we_i && priv && dec.sel == RS_DIAG) diag_q  <= wdata_i[0];
            if (we_i && priv && dec.sel == RS_PBLO) pb_lo_q <= wdata_i;
            if (we_i && priv && dec.sel == RS_PBHI) pb_hi_q <= wdata_i;
            if (we_i && dec.sel == RS_PMASK) pmask_q <= wdata_i;
            if (we_i && dec.sel == RS_ROP)   rop_q   <= wdata_i[7:0];
            if (we_i && dec.sel == RS_R0I)   r0i_q   <= wdata_i;
            if (we_i && dec.sel == RS_OVF)   ovf_q   <= '0;
            else if (overflow && ovf_q != OVF_MAX) ovf_q <= ovf_q + 1'b1;
        end
    end

    always_comb begin
        unique case (dec.sel)
            RS_STAT:  rdata_o = {16'h0, q_empty_i, go_o, wo_q, pb_en_q, 4'h0, ie, 1'b0, err};
            RS_ERR:   rdata_o = {24'h0, ie, 1'b0, err};
            RS_PBLO:  rdata_o = pb_lo_q;
            RS_PBHI:  rdata_o = pb_hi_q;
            RS_PMASK: rdata_o = pmask_q;
            RS_ROP:   rdata_o = {24'h0, rop_q};
            RS_OVF:   rdata_o = BUS_W'(ovf_q);
            RS_DIAG:  rdata_o = {31'h0, diag_q};
            RS_ID:    rdata_o = {16'h0, CHIP_REV, ARCH_ID};
            RS_R0I:   rdata_o = r0i_q;
            default:  rdata_o = '0;
        endcase
    end

    assign pb_en_o      = pb_en_q;
    assign pb_lo_o      = pb_lo_q;
    assign pb_hi_o      = pb_hi_q;
    assign plane_mask_o = pmask_q;
    assign rop_o        = rop_q;
    assign r0_init_o    = r0i_q;
    assign greg_we_o    = we_i && dec.dir_hit && !go_o;
    assign greg_idx_o   = dec.idx;
    assign greg_data_o  = wdata_i;
    assign q_push_o     = push_req && !q_full_i;
    assign q_kind_o     = dec.que_hit;
    assign q_reg_o      = dec.idx;
    assign q_data_o     = wdata_i;

    a_r5_direct_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        greg_we_o |-> !go_o);
    a_r5_running_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && dec.dir_hit && go_o) |=> err[E_REG_ACC]);
    a_r8_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_full_i |-> !q_push_o);
    a_r8_full_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && dec.que_hit && q_full_i) |=> err[E_Q_WRITE]);
    a_r4_user_pb_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && dec.user && (dec.sel == RS_PBLO || dec.sel == RS_PBHI))
            |=> ($stable(pb_lo_o) && $stable(pb_hi_o)));
    a_r3_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        srst |=> (!irq_o && plane_mask_o == '0 && !pb_en_o));
endmodule

// File: tb/test_rend_ctl_regs.sv
module test_rend_ctl_regs;
    localparam logic [7:0] ARCH = 8'h5A;
    localparam logic [7:0] REV  = 8'h03;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0, rdata;
    logic        go, pb_en, irq, greg_we, q_push, q_kind;
    logic [31:0] pb_lo, pb_hi, pmask, r0i, greg_data, q_data;
    logic [7:0]  rop;
    logic [6:0]  greg_idx, q_reg;
    logic        q_full = 1'b0, q_empty = 1'b1, wrote = 1'b0;
    logic [5:0]  eerr = '0;

    int n_tot = 0, n_bad = 0;
    logic        c_gwe, c_push, c_kind;
    logic [6:0]  c_gidx, c_qreg;
    logic [31:0] c_gdata, c_qdata, v;

    always #2 clk = ~clk;

    rend_ctl_regs #(.NREGS(128), .OVF_W(4), .ARCH_ID(ARCH), .CHIP_REV(REV)) i_rend_ctl_regs (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
        .rdata_o(rdata), .go_o(go), .pb_en_o(pb_en), .pb_lo_o(pb_lo), .pb_hi_o(pb_hi),
        .plane_mask_o(pmask), .rop_o(rop), .r0_init_o(r0i), .irq_o(irq),
        .greg_we_o(greg_we), .greg_idx_o(greg_idx), .greg_data_o(greg_data),
        .q_push_o(q_push), .q_kind_o(q_kind), .q_reg_o(q_reg), .q_data_o(q_data),
        .q_full_i(q_full), .q_empty_i(q_empty), .eng_err_i(eerr), .eng_wrote_i(wrote)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        #1;
        c_gwe = greg_we; c_gidx = greg_idx; c_gdata = greg_data;
        c_push = q_push; c_kind = q_kind; c_qreg = q_reg; c_qdata = q_data;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse_err(input logic [5:0] e);
        @(negedge clk); eerr = e;
        @(negedge clk); eerr = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tot++; n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(13'h000, v); chk("R1 status", v, 32'h8000);
        rd(13'h004, v); chk("R1 error", v, 0);
        for (int o = 8; o <= 'h2C; o += 4) begin
            if (o != 'h20 && o != 'h28) begin
                rd(13'(o), v); chk($sformatf("R1 word %h", o), v, 0);
            end
        end
        rd(13'h028, v); chk("R1 id", v, {16'h0, REV, ARCH});
        chk("R1 go/irq", {30'h0, go, irq}, 0);

        // R12 plain registers
        wr(13'h010, 32'hA5A5_F00F); wr(13'h014, 32'h1234_56C3);
        wr(13'h02C, 32'hCAFE_0001); wr(13'h008, 32'h0001_0000); wr(13'h00C, 32'h0002_0000);
        rd(13'h010, v); chk("R12 pmask", v, 32'hA5A5_F00F);
        rd(13'h014, v); chk("R12 rop", v, 32'hC3);
        rd(13'h02C, v); chk("R12 r0init", v, 32'hCAFE_0001);
        chk("R12 outputs", pmask ^ {24'h0, rop} ^ r0i ^ pb_lo ^ pb_hi,
            32'hA5A5_F00F ^ 32'hC3 ^ 32'hCAFE_0001 ^ 32'h0001_0000 ^ 32'h0002_0000);

        // R4 mirror view
        rd(13'h1010, v); chk("R4 mirror read", v, 32'hA5A5_F00F);
        wr(13'h1008, 32'hFFFF_FFFF); wr(13'h100C, 32'hFFFF_FFFF);
        rd(13'h008, v); chk("R4 user pb lo ignored", v, 32'h0001_0000);
        chk("R4 user pb hi ignored", pb_hi, 32'h0002_0000);
        wr(13'h101C, 32'h1); rd(13'h01C, v); chk("R4 user diag ignored", v, 0);
        wr(13'h1000, 32'h1000); chk("R4 user pb enable ignored", {31'h0, pb_en}, 0);
        wr(13'h0000, 32'h1000); rd(13'h1000, v); chk("R4 priv pb enable / R11 bit12", v & 32'h1000, 32'h1000);
        wr(13'h1010, 32'h0F0F_0F0F); chk("R4 user pmask writable", pmask, 32'h0F0F_0F0F);

        // R5 direct window, stopped: all registers
        for (int r = 0; r < 128; r++) begin
            wr(13'(256 + 4 * r), 32'hD000_0000 | (r * 32'h101));
            chk($sformatf("R5 direct r%0d", r), {c_gwe, 17'h0, c_gidx, 7'h0} ^ c_gdata,
                {1'b1, 17'h0, 7'(r), 7'h0} ^ (32'hD000_0000 | (r * 32'h101)));
        end
        rd(13'h004, v); chk("R5 no error when stopped", v, 0);

        // R2 start
        wr(13'h000, 32'h5000);
        chk("R2 go_o", {31'h0, go}, 1);
        rd(13'h000, v); chk("R2 status bit14", v & 32'h4000, 32'h4000);

        // R5 direct window while running
        for (int r = 0; r < 128; r++) begin
            wr(13'(256 + 4 * r), 32'h1111_0000 + r);
            chk($sformatf("R5 running drop r%0d", r), {31'h0, c_gwe}, 0);
        end
        rd(13'h004, v); chk("R5 illegal reg access bit3", v, 32'h08);
        wr(13'h004, 32'h08); rd(13'h004, v); chk("R9 w1c via error word", v, 0);

        // R6 queued window, running
        for (int r = 0; r < 128; r++) begin
            wr(13'(768 + 4 * r), ~(32'(r) * 32'h0001_0003));
            chk($sformatf("R6 queued r%0d", r), {c_push, c_kind, 23'h0, c_qreg} ^ c_qdata,
                {2'b11, 23'h0, 7'(r)} ^ ~(32'(r) * 32'h0001_0003));
        end

        // R7 instruction register
        wr(13'h020, 32'h9000_0001);
        chk("R7 plain insn push", {c_push, c_kind} ^ c_qdata, {2'b10} ^ 32'h9000_0001);
        wr(13'h020, 32'h8000_0042);
        chk("R7 mem insn blocked", {31'h0, c_push}, 0);
        rd(13'h004, v); chk("R7 illegal insn bit0", v, 32'h01);
        wr(13'h01C, 32'h1);
        wr(13'h020, 32'h8000_0042);
        chk("R7 mem insn allowed", {c_push, c_kind} ^ c_qdata, {2'b10} ^ 32'h8000_0042);
        wr(13'h004, 32'h3F);

        // R8 queue full, counter saturates at 15 (4-bit)
        q_full = 1'b1;
        for (int k = 1; k <= 20; k++) begin
            if (k % 2 == 0) wr(13'(768 + 4 * k), 32'(k));
            else            wr(13'h020, 32'(k));
            rd(13'h018, v);
            chk($sformatf("R8 overflow count %0d", k), {c_push, v[30:0]}, (k < 15) ? 32'(k) : 32'd15);
        end
        rd(13'h004, v); chk("R8 queue write error bit5", v, 32'h20);
        wr(13'h018, 32'h0); rd(13'h018, v); chk("R8 counter clear", v, 0);
        q_full = 1'b0;
        wr(13'h004, 32'h20);

        // R9 / R10 each engine error cause, with interrupt enabled
        wr(13'h004, 32'h80);
        for (int i = 0; i < 6; i++) begin
            chk($sformatf("R10 irq idle b%0d", i), {31'h0, irq}, 0);
            pulse_err(6'(1 << i));
            repeat (3) @(negedge clk);
            rd(13'h004, v); chk($sformatf("R9 sticky b%0d", i), v, 32'h80 | (1 << i));
            chk($sformatf("R10 irq b%0d", i), {31'h0, irq}, 1);
            wr(13'h000, 32'h5080 | (1 << i));
            rd(13'h004, v); chk($sformatf("R9 w1c status b%0d", i), v, 32'h80);
        end
        // set and clear on the same edge: set wins
        @(negedge clk); addr = 13'h004; wdata = 32'h82; we = 1'b1; eerr = 6'h02;
        @(negedge clk); we = 1'b0; eerr = '0;
        rd(13'h004, v); chk("R9 set wins over clear", v, 32'h82);
        wr(13'h004, 32'h00);
        chk("R10 irq off when disabled", {31'h0, irq}, 0);

        // R11 write-occurred flag and queue empty
        @(negedge clk); wrote = 1'b1; @(negedge clk); wrote = 1'b0;
        rd(13'h000, v); chk("R11 wrote flag", v & 32'h2000, 32'h2000);
        wr(13'h000, 32'h6000); rd(13'h000, v); chk("R11 wrote w1c", v & 32'h2000, 0);
        q_empty = 1'b0; rd(13'h000, v); chk("R11 empty low", v & 32'h8000, 0);
        q_empty = 1'b1;

        // R3 soft reset with state set up
        wr(13'h004, 32'h80); pulse_err(6'h10);
        chk("R3 pre irq", {31'h0, irq}, 1);
        wr(13'h030, 32'h0);
        chk("R3 go cleared", {31'h0, go}, 0);
        rd(13'h000, v); chk("R3 status", v, 32'h8000);
        rd(13'h004, v); chk("R3 error", v, 0);
        rd(13'h01C, v); chk("R3 diag", v, 0);
        chk("R3 outputs", pmask | {24'h0, rop} | r0i | pb_lo | pb_hi | {30'h0, irq, pb_en}, 0);

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end
endmodule